// File: doc/BRIEF.md
# Rotating Multi-Context Execution Core

This block is a small barrel-style processor core. Four independent instruction contexts share one execution datapath. Each context has its own program counter, its own four-entry register file and its own instruction store. A fixed rotation hands the datapath to one context per clock cycle. In that one cycle the owning context fetches its instruction, executes it and writes the result back, so no context can ever see a hazard from another one.

The contexts share nothing except a single data memory. Storing to it and loading from it is the only way one program can pass values to another. Only one context owns the datapath in any cycle, so the data memory serves exactly one access per cycle. That is the full data-side rate the rotation needs, and no further arbitration is required.

Each context has its own write port for loading its program. A run input gates the whole core. Debug outputs show the current slot, every program counter, every halt flag and a combinational read of any data word.

Top module: `rotor_core`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the slot to 0, every program counter to 0, every halt flag to 0 and every data word to 0. Instruction stores are not cleared.
- R2: While run is high, the slot advances by one at each clock edge: 0, 1, 2, 3, 0 and so on. The context named by dbg_slot executes exactly one instruction at the next edge.
- R3: A context's program counter, registers and halt flag change only at an edge that falls in its own slot. While run is low, the slot and all context state hold.
- R4: Writing through context k's load port changes only context k's instruction store. No other context fetches from it.
- R5: Instruction fields are as follows. The opcode is bits [15:13]: 0 halt, 1 add, 2 sub, 3 and, 4 load-immediate, 5 load, 6 store, 7 branch-if-zero. The destination register is bits [12:11], the first source is bits [10:9] and the second source is bits [8:7]. The immediate is bits [7:0]. The data address or branch target is bits [3:0].
- R6: add, sub and and write the 8-bit result (rd = ra op rb, modulo 256) to the destination register.
- R7: Store writes register ra to data word [3:0]. Load writes data word [3:0] to rd. A value stored by one context is returned to a later load from a different context.
- R8: Branch-if-zero sets the program counter to the target when register ra is zero, and to pc+1 otherwise. Every other non-halt instruction sets it to pc+1. The program counter wraps from 15 to 0.
- R9: Halt sets the context's halt flag and freezes its program counter until reset. The halted context's slot still passes, so the other contexts keep a period of four cycles.
- R10: dbg_ddata shows the data word selected by dbg_daddr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Lets the rotation advance and the slot owner execute |
| ld_we | input | 4 | Per-context instruction-store write enable |
| ld_addr | input | 16 | Per-context write address, 4 bits per context (context k at [4k+3:4k]) |
| ld_data | input | 64 | Per-context instruction word, 16 bits per context |
| dbg_slot | output | 2 | Context that owns the next edge |
| dbg_pc | output | 16 | Program counters, 4 bits per context |
| dbg_halt | output | 4 | Halt flag per context |
| dbg_daddr | input | 4 | Data word selected for debug read |
| dbg_ddata | output | 8 | Debug read data |

## Verification
A wrong slot counter shows up within one cycle as a program counter that moves outside its slot. A wrong per-context state shows up after at most four cycles, the next visit of that context, as a program counter value that does not match. ALU, load, store and branch faults are not visible directly. They appear in the data memory once the affected program stores a result, usually a few rounds later, and a mispredicted branch also leaves the final halt address off by the skipped instructions. The timing checks look at program counters after exact cycle counts, so the bench also catches a rotation that keeps the right order but has the wrong period.

// File: rtl/rotor_pkg.sv
// Shared definitions for the rotating multi-context core.
// Assumes a fixed 16-bit instruction layout; field positions live in rotor_exec.
package rotor_pkg;
    typedef enum logic [2:0] {
        OP_HALT = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_LDI  = 3'd4,
        OP_LD   = 3'd5,
        OP_ST   = 3'd6,
        OP_BZ   = 3'd7
    } op_e;
endpackage

// File: rtl/rotor_sched.sv
// Slot scheduler: a modulo-NCTX counter that names the context owning the
// datapath for the coming edge, plus a one-hot select per context.
// Assumes run is synchronous; when run is low no context is selected.
module rotor_sched #(
    parameter int NCTX = 4,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [CW-1:0]   slot,
    output logic [NCTX-1:0] sel
);
    localparam logic [CW-1:0] LAST = CW'(NCTX - 1);

    // Advance the rotation by one slot per running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (run)
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end

    // Decode the slot into per-context execute enables.
    for (genvar k = 0; k < NCTX; k++) begin : g_sel
        assign sel[k] = run && (slot == CW'(k));
    end

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (slot == (($past(slot) == LAST) ? '0 : CW'($past(slot) + 1'b1))));

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(slot));

    // R2
    sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/rotor_ctx.sv
// One hardware context: private instruction store, program counter,
// register file and halt flag. The state updates only when sel is high.
// Assumes the update bundle comes from the shared executor in the same cycle.
module rotor_ctx #(
    parameter int IW     = 16,
    parameter int DW     = 8,
    parameter int IDEPTH = 16,
    parameter int NREG   = 4,
    localparam int IAW = $clog2(IDEPTH),
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           ld_we,
    input  logic [IAW-1:0] ld_addr,
    input  logic [IW-1:0]  ld_data,
    input  logic [RAW-1:0] rd_a,
    input  logic [RAW-1:0] rd_b,
    input  logic [IAW-1:0] pc_nxt,
    input  logic           halt_set,
    input  logic           rf_we,
    input  logic [RAW-1:0] rf_wa,
    input  logic [DW-1:0]  rf_wd,
    output logic [IW-1:0]  instr,
    output logic [DW-1:0]  va,
    output logic [DW-1:0]  vb,
    output logic [IAW-1:0] pc,
    output logic           halted
);
    logic [IW-1:0] imem [IDEPTH];
    logic [DW-1:0] regs [NREG];

    // Program load through this context's own port.
    always_ff @(posedge clk) begin
        if (ld_we)
            imem[ld_addr] <= ld_data;
    end

    // Fetch and register reads are combinational within the slot.
    assign instr = imem[pc];
    assign va    = regs[rd_a];
    assign vb    = regs[rd_b];

    // Commit the executor's results in this context's slot only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            halted <= 1'b0;
            for (int r = 0; r < NREG; r++)
                regs[r] <= '0;
        end else if (sel && !halted) begin
            pc     <= pc_nxt;
            halted <= halt_set;
            if (rf_we)
                regs[rf_wa] <= rf_wd;
        end
    end

    // R3
    pc_own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(pc));

    // R9
    halt_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));
endmodule

// File: rtl/rotor_exec.sv
// Shared executor: decodes the slot owner's instruction and computes the
// next program counter, register write and data-memory access in one cycle.
// Assumes the 16-bit layout: op[15:13] rd[12:11] ra[10:9] rb[8:7] imm[7:0].
module rotor_exec
    import rotor_pkg::*;
#(
    parameter int IW     = 16,
    parameter int DW     = 8,
    parameter int IDEPTH = 16,
    parameter int DDEPTH = 16,
    parameter int NREG   = 4,
    localparam int IAW = $clog2(IDEPTH),
    localparam int DAW = $clog2(DDEPTH),
    localparam int RAW = $clog2(NREG)
) (
    input  logic [IW-1:0]  instr,
    input  logic [DW-1:0]  va,
    input  logic [DW-1:0]  vb,
    input  logic [IAW-1:0] pc,
    input  logic           halted,
    input  logic [DW-1:0]  dm_rdata,
    output logic [IAW-1:0] pc_nxt,
    output logic           halt_set,
    output logic           rf_we,
    output logic [RAW-1:0] rf_wa,
    output logic [DW-1:0]  rf_wd,
    output logic           dm_we,
    output logic [DAW-1:0] dm_addr,
    output logic [DW-1:0]  dm_wdata
);
    op_e op;
    assign op = op_e'(instr[15:13]);

    // Decode and execute the current instruction.
    always_comb begin
        pc_nxt   = IAW'(pc + 1'b1);
        halt_set = 1'b0;
        rf_we    = 1'b0;
        rf_wa    = instr[12:11];
        rf_wd    = '0;
        dm_we    = 1'b0;
        dm_addr  = instr[DAW-1:0];
        dm_wdata = va;
        unique case (op)
            OP_HALT: begin
                pc_nxt   = pc;
                halt_set = 1'b1;
            end
            OP_ADD: begin rf_we = 1'b1; rf_wd = va + vb; end
            OP_SUB: begin rf_we = 1'b1; rf_wd = va - vb; end
            OP_AND: begin rf_we = 1'b1; rf_wd = va & vb; end
            OP_LDI: begin rf_we = 1'b1; rf_wd = instr[DW-1:0]; end
            OP_LD:  begin rf_we = 1'b1; rf_wd = dm_rdata; end
            OP_ST:  dm_we = 1'b1;
            OP_BZ:  if (va == '0) pc_nxt = instr[IAW-1:0];
            default: ;
        endcase
        if (halted) begin
            pc_nxt   = pc;
            halt_set = 1'b1;
            rf_we    = 1'b0;
            dm_we    = 1'b0;
        end
    end

    // R9
    halt_no_write_chk: assert final (!(halted && (rf_we || dm_we)));
endmodule

// File: rtl/rotor_dmem.sv
// Common data memory: one write/read port for the slot owner and one
// combinational debug read port. Cleared by reset.
// Assumes a single access per cycle, which the rotation guarantees.
module rotor_dmem #(
    parameter int DW     = 8,
    parameter int DDEPTH = 16,
    localparam int DAW = $clog2(DDEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [DAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [DAW-1:0] dbg_addr,
    output logic [DW-1:0]  dbg_data
);
    logic [DW-1:0] mem [DDEPTH];

    // Clear on reset, otherwise take the slot owner's store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DDEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Both reads are asynchronous.
    assign rdata    = mem[addr];
    assign dbg_data = mem[dbg_addr];

    // R7
    store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/rotor_core.sv
// Top of the rotating multi-context core: four contexts share one executor
// and one data memory, taking turns one cycle each.
// Assumes program loads are done by the user while the target context is idle.
module rotor_core #(
    parameter int NCTX   = 4,
    parameter int IW     = 16,
    parameter int DW     = 8,
    parameter int IDEPTH = 16,
    parameter int DDEPTH = 16,
    parameter int NREG   = 4,
    localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int IAW = $clog2(IDEPTH),
    localparam int DAW = $clog2(DDEPTH),
    localparam int RAW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [NCTX-1:0]     ld_we,
    input  logic [NCTX*IAW-1:0] ld_addr,
    input  logic [NCTX*IW-1:0]  ld_data,
    output logic [CW-1:0]       dbg_slot,
    output logic [NCTX*IAW-1:0] dbg_pc,
    output logic [NCTX-1:0]     dbg_halt,
    input  logic [DAW-1:0]      dbg_daddr,
    output logic [DW-1:0]       dbg_ddata
);
    logic [CW-1:0]   slot;
    logic [NCTX-1:0] sel;

    logic [IW-1:0]  instr_v [NCTX];
    logic [DW-1:0]  va_v    [NCTX];
    logic [DW-1:0]  vb_v    [NCTX];
    logic [IAW-1:0] pc_v    [NCTX];
    logic [NCTX-1:0] halt_v;

    logic [IW-1:0]  cur_instr;
    logic [RAW-1:0] rd_a, rd_b;
    logic [IAW-1:0] pc_nxt;
    logic           halt_set, rf_we, dm_we;
    logic [RAW-1:0] rf_wa;
    logic [DW-1:0]  rf_wd, dm_wdata, dm_rdata;
    logic [DAW-1:0] dm_addr;

    rotor_sched #(.NCTX(NCTX)) u_sched (
        .clk(clk), .rst_n(rst_n), .run(run), .slot(slot), .sel(sel)
    );

    // One context per slot; all see the same update bundle.
    for (genvar k = 0; k < NCTX; k++) begin : g_ctx
        rotor_ctx #(.IW(IW), .DW(DW), .IDEPTH(IDEPTH), .NREG(NREG)) u_ctx (
            .clk(clk), .rst_n(rst_n), .sel(sel[k]),
            .ld_we(ld_we[k]),
            .ld_addr(ld_addr[k*IAW +: IAW]),
            .ld_data(ld_data[k*IW +: IW]),
            .rd_a(rd_a), .rd_b(rd_b),
            .pc_nxt(pc_nxt), .halt_set(halt_set),
            .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
            .instr(instr_v[k]), .va(va_v[k]), .vb(vb_v[k]),
            .pc(pc_v[k]), .halted(halt_v[k])
        );
        assign dbg_pc[k*IAW +: IAW] = pc_v[k];
    end

    // Route the slot owner's fetch to the executor.
    assign cur_instr = instr_v[slot];
    assign rd_a      = cur_instr[10:9];
    assign rd_b      = cur_instr[8:7];

    rotor_exec #(.IW(IW), .DW(DW), .IDEPTH(IDEPTH), .DDEPTH(DDEPTH), .NREG(NREG)) u_exec (
        .instr(cur_instr), .va(va_v[slot]), .vb(vb_v[slot]),
        .pc(pc_v[slot]), .halted(halt_v[slot]), .dm_rdata(dm_rdata),
        .pc_nxt(pc_nxt), .halt_set(halt_set),
        .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
        .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata)
    );

    rotor_dmem #(.DW(DW), .DDEPTH(DDEPTH)) u_dmem (
        .clk(clk), .rst_n(rst_n), .we(run && dm_we),
        .addr(dm_addr), .wdata(dm_wdata), .rdata(dm_rdata),
        .dbg_addr(dbg_daddr), .dbg_data(dbg_ddata)
    );

    assign dbg_slot = slot;
    assign dbg_halt = halt_v;

    // R3
    run_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(dbg_pc) && $stable(dbg_halt)));
endmodule

// File: tb/rotor_core_test.sv
module rotor_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic [3:0]  ld_we;
    logic [15:0] ld_addr;
    logic [63:0] ld_data;
    logic [1:0]  dbg_slot;
    logic [15:0] dbg_pc;
    logic [3:0]  dbg_halt;
    logic [3:0]  dbg_daddr;
    logic [7:0]  dbg_ddata;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] prog [4][16];

    always #(CLK_PERIOD/2) clk = ~clk;

    rotor_core uut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_slot(dbg_slot), .dbg_pc(dbg_pc), .dbg_halt(dbg_halt),
        .dbg_daddr(dbg_daddr), .dbg_ddata(dbg_ddata)
    );

    function automatic logic [15:0] i_alu(input logic [2:0] op, input logic [1:0] rd,
                                          input logic [1:0] ra, input logic [1:0] rb);
        return {op, rd, ra, rb, 7'b0};
    endfunction
    function automatic logic [15:0] i_ldi(input logic [1:0] rd, input logic [7:0] imm);
        return {3'd4, rd, 3'b0, imm};
    endfunction
    function automatic logic [15:0] i_ld(input logic [1:0] rd, input logic [3:0] a);
        return {3'd5, rd, 7'b0, a};
    endfunction
    function automatic logic [15:0] i_st(input logic [1:0] ra, input logic [3:0] a);
        return {3'd6, 2'b0, ra, 5'b0, a};
    endfunction
    function automatic logic [15:0] i_bz(input logic [1:0] ra, input logic [3:0] t);
        return {3'd7, 2'b0, ra, 5'b0, t};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pc_of(input int k);
        return int'(dbg_pc[k*4 +: 4]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic clear_progs();
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 16; a++)
                prog[k][a] = 16'h0000;
    endtask

    task automatic load_all();
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 16; a++) begin
                ld_we = '0;
                ld_we[k] = 1'b1;
                ld_addr[k*4 +: 4] = 4'(a);
                ld_data[k*16 +: 16] = prog[k][a];
                @(negedge clk);
            end
        end
        ld_we = '0;
    endtask

    task automatic run_cycles(input int n);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
    endtask

    task automatic mem_word(input int a, output int v);
        dbg_daddr = 4'(a);
        #1;
        v = int'(dbg_ddata);
    endtask

    // R2 R3 R5 R6 R7 R8 R10: four different programs sharing data memory
    task automatic test_programs();
        int v;
        int exp_mem [16];
        do_reset();
        clear_progs();
        prog[0][0] = i_ldi(0, 8'h5A);
        prog[0][1] = i_ldi(1, 8'h33);
        prog[0][2] = i_alu(3'd1, 2, 0, 1);
        prog[0][3] = i_st(2, 4'd0);
        prog[0][4] = i_alu(3'd2, 3, 1, 0);
        prog[0][5] = i_st(3, 4'd1);
        prog[0][6] = i_alu(3'd3, 2, 0, 1);
        prog[0][7] = i_st(2, 4'd2);
        prog[1][0] = i_ldi(0, 8'hFF);
        prog[1][1] = i_ldi(1, 8'h02);
        prog[1][2] = i_alu(3'd1, 2, 0, 1);
        prog[1][3] = i_st(2, 4'd3);
        for (int a = 0; a < 5; a++) prog[2][a] = i_ldi(3, 8'h00);
        prog[2][5] = i_ld(1, 4'd0);
        prog[2][6] = i_st(1, 4'd5);
        prog[3][0] = i_ldi(0, 8'h00);
        prog[3][1] = i_bz(0, 4'd5);
        prog[3][2] = i_ldi(1, 8'hEE);
        prog[3][3] = i_st(1, 4'd6);
        prog[3][5] = i_ldi(1, 8'h44);
        prog[3][6] = i_bz(1, 4'd2);
        prog[3][7] = i_st(1, 4'd7);
        load_all();

        run_cycles(1);
        chk("R2 slot after one edge", int'(dbg_slot), 1);
        chk("R2 ctx0 pc after its slot", pc_of(0), 1);
        chk("R3 ctx1 pc untouched", pc_of(1), 0);
        chk("R3 ctx3 pc untouched", pc_of(3), 0);
        repeat (3) @(negedge clk);
        chk("R3 slot frozen while idle", int'(dbg_slot), 1);
        chk("R3 ctx0 pc frozen while idle", pc_of(0), 1);

        run_cycles(47);
        chk("R9 ctx0 halt pc", pc_of(0), 8);
        chk("R9 ctx1 halt pc", pc_of(1), 4);
        chk("R9 ctx2 halt pc", pc_of(2), 7);
        chk("R8 ctx3 halt pc after branches", pc_of(3), 8);
        chk("R9 all halted", int'(dbg_halt), 4'hF);

        for (int a = 0; a < 16; a++) exp_mem[a] = 0;
        exp_mem[0] = 8'h8D;  // R6 add
        exp_mem[1] = 8'hD9;  // R6 sub wraps
        exp_mem[2] = 8'h12;  // R6 and
        exp_mem[3] = 8'h01;  // R6 add wraps
        exp_mem[5] = 8'h8D;  // R7 passed between contexts
        exp_mem[7] = 8'h44;  // R8 taken then not-taken branch
        for (int a = 0; a < 16; a++) begin
            mem_word(a, v);
            chk($sformatf("R7 R10 data word %0d", a), v, exp_mem[a]);
        end
    endtask

    // R1: reset state after a run left data behind
    task automatic test_reset();
        int v;
        int nz;
        do_reset();
        chk("R1 slot", int'(dbg_slot), 0);
        chk("R1 pcs", int'(dbg_pc), 0);
        chk("R1 halt flags", int'(dbg_halt), 0);
        nz = 0;
        for (int a = 0; a < 16; a++) begin
            mem_word(a, v);
            if (v != 0) nz++;
        end
        chk("R1 data words cleared", nz, 0);
    endtask

    // R4 R9: one live context among halted ones keeps a four-cycle period
    task automatic test_private_halt();
        int v;
        do_reset();
        clear_progs();
        prog[1][0] = i_ldi(0, 8'h21);
        prog[1][1] = i_st(0, 4'd9);
        load_all();
        run_cycles(5);
        chk("R4 ctx0 halts on own store", pc_of(0), 0);
        chk("R4 ctx2 halts on own store", pc_of(2), 0);
        chk("R9 ctx1 one instruction in five cycles", pc_of(1), 1);
        chk("R9 halt flags of idle contexts", int'(dbg_halt), 4'b1101);
        run_cycles(1);
        chk("R9 ctx1 second slot on sixth cycle", pc_of(1), 2);
        mem_word(9, v);
        chk("R7 store from ctx1", v, 8'h21);
        run_cycles(4);
        chk("R9 ctx1 halted at pc2", pc_of(1), 2);
        chk("R9 all halted", int'(dbg_halt), 4'hF);
    endtask

    // R8: program counter wraps from 15 to 0
    task automatic test_wrap();
        int v;
        do_reset();
        clear_progs();
        for (int a = 0; a < 15; a++) prog[0][a] = i_ldi(0, 8'(a));
        prog[0][15] = i_st(0, 4'd10);
        load_all();
        run_cycles(64);
        chk("R8 pc wrapped to 0", pc_of(0), 0);
        chk("R8 ctx0 not halted", int'(dbg_halt[0]), 0);
        mem_word(10, v);
        chk("R8 store at last address", v, 8'h0E);
        run_cycles(4);
        chk("R8 pc continues after wrap", pc_of(0), 1);
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0;
        ld_we = '0; ld_addr = '0; ld_data = '0; dbg_daddr = '0;
        test_programs();
        test_reset();
        test_private_halt();
        test_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule